// File: doc/BRIEF.md
# Caller-Data Serial Word Interface

This block turns a stream of demodulated FSK bits into 8-bit words and delivers them over a three-wire serial port. The port has a data line, a shift clock and an active-low word strobe. The incoming bits arrive at a fixed baud rate with asynchronous framing: a low start bit, eight data bits with the least significant first, and a high stop bit. The block oversamples each bit and takes its value at the centre of the bit.

A mode input picks how words leave the block.

- **Push mode (mode 0):** the block drives the shift clock itself. Each data bit is placed on the data line as soon as it has been sampled, and one clock pulse goes with it. After the eighth pulse of a word, the strobe goes low for a short time to mark the word boundary.
- **Pull mode (mode 1):** a host supplies the shift clock. The strobe goes low once a whole word is held. Each rising host edge presents the next bit. If a new word lands before the host has read the old one, the new word replaces it and a sticky overrun flag is set.

An open-drain interrupt output pulls low while any of three sources is active: the trigger input is low, the strobe is low, or the tone-detect flag is high. It floats again only when all three are inactive.

Top module: `serial_word_if`

## Requirements
- R1: A word is accepted only from a frame with a low start bit (still low at mid-bit), eight data bits taken LSB first at the centres of the bits, and a stop bit sampled high.
- R2: In mode 0, each data bit is driven on `data_o` at the same clock edge as `dclk_o` rises, and `dclk_o` stays high for `DCLK_HI` cycles. A word gives exactly eight pulses, LSB first.
- R3: In mode 0, `dr_no` falls at the edge where the eighth `dclk_o` pulse of a word falls, and stays low for `DR_LOW` cycles.
- R4: In mode 1, `dr_no` goes low once a complete, valid word has been received.
- R5: In mode 1, each rising edge of `dclk_i` puts the next bit of the held word on `data_o`, LSB first. The first edge shows bit 0.
- R6: In mode 1, `dr_no` returns high after the eighth rising `dclk_i` edge of the word. Further edges leave it high.
- R7: In mode 1, a word completing while the previous one is unread replaces it, and `ovr_o` rises and stays high until reset.
- R8: In mode 1, a frame whose stop bit samples low delivers no word: `dr_no` stays high.
- R9: `irq_no` is driven low while `trig_ni` is low, `dr_no` is low or `tone_i` is high. It is high-impedance only when all three are inactive.
- R10: In mode 1, `dclk_o` stays low. In mode 0, `dclk_i` has no effect on `data_o` or `dr_no`.
- R11: After reset, `data_o`=0, `dclk_o`=0, `dr_no`=1, `ovr_o`=0 and `irq_no` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Demodulated bit, sampled on clk_i, idle high |
| mode_i | input | 1 | 0 = device-clocked push, 1 = host-clocked pull |
| dclk_i | input | 1 | Host shift clock (mode 1), asynchronous |
| tone_i | input | 1 | Tone-detect flag, active high |
| trig_ni | input | 1 | Trigger flag, active low |
| data_o | output | 1 | Serial data |
| dclk_o | output | 1 | Device shift clock (mode 0) |
| dr_no | output | 1 | Data-ready strobe, active low |
| ovr_o | output | 1 | Sticky overrun flag (mode 1) |
| irq_no | output | 1 | Open-drain interrupt, active low |

## Verification
The hardest case is the overrun in pull mode. The bench has to hold a word unread across a whole second frame, and then confirm that the later word is the one shifted out. It does this by sending two frames back to back with the host clock idle. It then checks that the flag is raised, and clocks out eight bits that must match the second byte. A second hard case is a bad stop bit. Here the line sits low past the stop sample, so a false start is seen and must be rejected at its mid-bit check. The bench drives such a frame and then confirms that the strobe never drops.

// File: rtl/serial_word_pkg.sv
`timescale 1ns/1ps
package serial_word_pkg;
  localparam int unsigned WORD_W = 8;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sw_deframer.sv
`timescale 1ns/1ps
module sw_deframer
  import serial_word_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rx_bit_i,
  output logic  bit_stb_o,
  output logic  bit_val_o,
  output logic  bit_last_o,
  output logic  word_stb_o,
  output word_t word_o
);
  localparam int unsigned CW   = $clog2(CLKS_PER_BIT);
  localparam int unsigned IW   = $clog2(WORD_W);
  localparam int unsigned HALF = CLKS_PER_BIT / 2;

  rx_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic [IW-1:0]  idx_q;
  word_t          sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      sh_q       <= '0;
      bit_stb_o  <= 1'b0;
      bit_val_o  <= 1'b0;
      bit_last_o <= 1'b0;
      word_stb_o <= 1'b0;
      word_o     <= '0;
    end else begin
      bit_stb_o  <= 1'b0;
      word_stb_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: if (!rx_bit_i) begin
          state_q <= RX_START;
          cnt_q   <= CW'(HALF - 1);
        end
        RX_START: if (cnt_q == '0) begin
          // false start rejected at mid-bit
          state_q <= rx_bit_i ? RX_IDLE : RX_DATA;
          cnt_q   <= CW'(CLKS_PER_BIT - 1);
          idx_q   <= '0;
        end else cnt_q <= cnt_q - 1'b1;
        RX_DATA: if (cnt_q == '0) begin
          bit_stb_o  <= 1'b1;
          bit_val_o  <= rx_bit_i;
          bit_last_o <= (idx_q == IW'(WORD_W - 1));
          sh_q       <= {rx_bit_i, sh_q[WORD_W-1:1]};
          idx_q      <= idx_q + 1'b1;
          cnt_q      <= CW'(CLKS_PER_BIT - 1);
          if (idx_q == IW'(WORD_W - 1)) state_q <= RX_STOP;
        end else cnt_q <= cnt_q - 1'b1;
        RX_STOP: if (cnt_q == '0) begin
          if (rx_bit_i) begin
            word_stb_o <= 1'b1;
            word_o     <= sh_q;
          end
          state_q <= RX_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  // R1
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |-> $past(rx_bit_i));
endmodule

// File: rtl/sw_push_tx.sv
`timescale 1ns/1ps
module sw_push_tx #(
  parameter int unsigned DCLK_HI = 4,
  parameter int unsigned DR_LOW  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_stb_i,
  input  logic bit_val_i,
  input  logic bit_last_i,
  output logic data_o,
  output logic dclk_o,
  output logic dr_no
);
  localparam int unsigned HW = $clog2(DCLK_HI + 1);
  localparam int unsigned DW = $clog2(DR_LOW + 1);

  logic [HW-1:0] hi_q;
  logic [DW-1:0] dr_q;
  logic          last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      dr_q   <= '0;
      last_q <= 1'b0;
      data_o <= 1'b0;
    end else if (!en_i) begin
      hi_q <= '0;
      dr_q <= '0;
    end else begin
      if (hi_q != '0) hi_q <= hi_q - 1'b1;
      if (dr_q != '0) dr_q <= dr_q - 1'b1;
      // strobe opens as the last pulse closes
      if (hi_q == HW'(1) && last_q) dr_q <= DW'(DR_LOW);
      if (bit_stb_i) begin
        data_o <= bit_val_i;
        hi_q   <= HW'(DCLK_HI);
        last_q <= bit_last_i;
      end
    end
  end

  assign dclk_o = (hi_q != '0);
  assign dr_no  = (dr_q == '0);

  // R2
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dclk_o) |-> $past(bit_stb_i));
  // R3
  dr_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dr_no) |-> $fell(dclk_o));
endmodule

// File: rtl/sw_pull_tx.sv
`timescale 1ns/1ps
module sw_pull_tx
  import serial_word_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  dclk_i,
  input  logic  word_stb_i,
  input  word_t word_i,
  output logic  data_o,
  output logic  dr_no,
  output logic  ovr_o
);
  localparam int unsigned IW = $clog2(WORD_W);

  logic [2:0]    sync_q;
  logic          rise;
  word_t         sh_q;
  logic [IW-1:0] cnt_q;
  logic          avail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], dclk_i};
  end
  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      avail_q <= 1'b0;
      data_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else if (!en_i) begin
      avail_q <= 1'b0;
      cnt_q   <= '0;
    end else if (word_stb_i) begin
      if (avail_q) ovr_o <= 1'b1;
      sh_q    <= word_i;
      avail_q <= 1'b1;
      cnt_q   <= '0;
    end else if (rise && avail_q) begin
      data_o <= sh_q[0];
      sh_q   <= sh_q >> 1;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == IW'(WORD_W - 1)) avail_q <= 1'b0;
    end
  end

  assign dr_no = ~avail_q;

  // R4
  dr_on_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dr_no) |-> $past(word_stb_i));
  // R6
  dr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dr_no) |-> ($past(rise) || !$past(en_i)));
  // R7
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o);
endmodule

// File: rtl/serial_word_if.sv
`timescale 1ns/1ps
module serial_word_if
  import serial_word_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned DCLK_HI      = 4,
  parameter int unsigned DR_LOW       = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_bit_i,
  input  logic mode_i,
  input  logic dclk_i,
  input  logic tone_i,
  input  logic trig_ni,
  output logic data_o,
  output logic dclk_o,
  output logic dr_no,
  output wire  irq_no,
  output logic ovr_o
);
  logic  bit_stb, bit_val, bit_last, word_stb;
  word_t word;
  logic  push_data, push_dr, pull_data, pull_dr;
  logic  irq_act;

  sw_deframer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_deframer (
    .clk_i, .rst_ni, .rx_bit_i,
    .bit_stb_o(bit_stb), .bit_val_o(bit_val), .bit_last_o(bit_last),
    .word_stb_o(word_stb), .word_o(word)
  );

  sw_push_tx #(.DCLK_HI(DCLK_HI), .DR_LOW(DR_LOW)) u_push (
    .clk_i, .rst_ni, .en_i(~mode_i),
    .bit_stb_i(bit_stb), .bit_val_i(bit_val), .bit_last_i(bit_last),
    .data_o(push_data), .dclk_o(dclk_o), .dr_no(push_dr)
  );

  sw_pull_tx u_pull (
    .clk_i, .rst_ni, .en_i(mode_i), .dclk_i,
    .word_stb_i(word_stb), .word_i(word),
    .data_o(pull_data), .dr_no(pull_dr), .ovr_o(ovr_o)
  );

  assign data_o  = mode_i ? pull_data : push_data;
  assign dr_no   = mode_i ? pull_dr   : push_dr;
  assign irq_act = ~trig_ni | ~dr_no | tone_i;
  assign irq_no  = irq_act ? 1'b0 : 1'bz;

  // R10
  no_dclk_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && $past(mode_i)) |-> !dclk_o);
endmodule

// File: tb/serial_word_if_test.sv
`timescale 1ns/1ps
module serial_word_if_test;
  localparam int CPB = 16;
  localparam int HI  = 4;
  localparam int DRL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_bit = 1'b1, mode = 1'b0, dclk_in = 1'b0, tone = 1'b0, trig_n = 1'b1;
  logic data, dclk, dr_n, ovr;
  wire  irq_line;
  pullup (irq_line);

  int checks = 0, failures = 0;

  serial_word_if #(.CLKS_PER_BIT(CPB), .DCLK_HI(HI), .DR_LOW(DRL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .mode_i(mode),
    .dclk_i(dclk_in), .tone_i(tone), .trig_ni(trig_n),
    .data_o(data), .dclk_o(dclk), .dr_no(dr_n), .irq_no(irq_line), .ovr_o(ovr)
  );

  always #2 clk = ~clk;

  // mode-0 monitor, sampled on falling edges
  int   rise_cnt, dr_fall_cnt, dr_low_len, hi_run, bad_hi, dclk_pull;
  logic dr_fall_on_dclk;
  logic [7:0] mon_word;
  logic prev_dclk = 1'b0, prev_dr = 1'b1;

  always @(negedge clk) begin
    if (dclk && !prev_dclk) begin
      if (rise_cnt < 8) mon_word[rise_cnt] = data;
      rise_cnt++;
    end
    if (dclk) hi_run++;
    else if (prev_dclk) begin
      if (hi_run != HI) bad_hi++;
      hi_run = 0;
    end
    if (!dr_n && prev_dr && !mode) begin
      dr_fall_cnt     = rise_cnt;
      dr_fall_on_dclk = prev_dclk && !dclk;
    end
    if (!dr_n && !mode) dr_low_len++;
    if (mode && dclk) dclk_pull++;
    prev_dclk = dclk;
    prev_dr   = dr_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    rise_cnt = 0; dr_fall_cnt = -1; dr_low_len = 0; hi_run = 0; bad_hi = 0;
    dr_fall_on_dclk = 1'b0; mon_word = '0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    @(negedge clk) rx_bit = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_bit = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx_bit = stop;
    repeat (CPB) @(negedge clk);
    rx_bit = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_edge(output logic d);
    dclk_in = 1'b1;
    repeat (6) @(negedge clk);
    d = data;
    dclk_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 data", data, 0);
    chk("R11 dclk", dclk, 0);
    chk("R11 dr", dr_n, 1);
    chk("R11 ovr", ovr, 0);
    chk("R11 irq", irq_line, 1);
  endtask

  task automatic t_push(input logic [7:0] b);
    logic d0, r0;
    clr_mon();
    mode = 1'b0;
    send_frame(b, 1'b1);
    repeat (CPB) @(negedge clk);
    chk("R2 pulses", rise_cnt, 8);
    chk("R2 word", int'(mon_word), int'(b));
    chk("R2 width", bad_hi, 0);
    chk("R3 dr after 8th", dr_fall_cnt, 8);
    chk("R3 dr at fall", int'(dr_fall_on_dclk), 1);
    chk("R3 dr len", dr_low_len, DRL);
    // R10: host clock must not disturb push mode
    d0 = data; r0 = dr_n;
    for (int k = 0; k < 3; k++) host_edge(d0);
    chk("R10 data", data, int'(d0));
    chk("R10 dr", dr_n, int'(r0));
  endtask

  task automatic t_pull(input logic [7:0] b);
    logic [7:0] got;
    logic d;
    mode = 1'b1;
    repeat (2) @(negedge clk);
    send_frame(b, 1'b1);
    chk("R4 dr low", dr_n, 0);
    chk("R9 irq on dr", irq_line, 0);
    for (int i = 0; i < 8; i++) begin
      if (i == 7) chk("R6 dr low before 8th", dr_n, 0);
      host_edge(d);
      got[i] = d;
    end
    chk("R5 word", int'(got), int'(b));
    chk("R6 dr high", dr_n, 1);
    host_edge(d);
    chk("R6 extra edge", dr_n, 1);
    chk("R9 irq release", irq_line, 1);
    chk("R10 no dclk_o", dclk_pull, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] got;
    logic d;
    chk("R7 ovr clear", ovr, 0);
    send_frame(8'h3C, 1'b1);
    send_frame(8'hC6, 1'b1);
    chk("R7 ovr set", ovr, 1);
    for (int i = 0; i < 8; i++) begin
      host_edge(d);
      got[i] = d;
    end
    chk("R7 newest word", int'(got), 8'hC6);
    chk("R7 sticky", ovr, 1);
  endtask

  task automatic t_bad_stop();
    mode = 1'b1;
    send_frame(8'h77, 1'b0);
    repeat (3 * CPB) @(negedge clk);
    chk("R8 no word", dr_n, 1);
    chk("R1 no overrun", ovr, 0);
    // glitch shorter than half a bit is not a start
    @(negedge clk) rx_bit = 1'b0;
    repeat (CPB / 4) @(negedge clk);
    rx_bit = 1'b1;
    repeat (12 * CPB) @(negedge clk);
    chk("R1 glitch", dr_n, 1);
  endtask

  task automatic t_irq();
    chk("R9 idle", irq_line, 1);
    tone = 1'b1; @(negedge clk);
    chk("R9 tone", irq_line, 0);
    tone = 1'b0; trig_n = 1'b0; @(negedge clk);
    chk("R9 trig", irq_line, 0);
    tone = 1'b1; @(negedge clk);
    trig_n = 1'b1; @(negedge clk);
    chk("R9 one left", irq_line, 0);
    tone = 1'b0; @(negedge clk);
    chk("R9 all clear", irq_line, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    dclk_pull = 0;
    clr_mon();
    do_reset();
    t_reset();
    t_irq();
    t_push(8'h5A);
    t_push(8'h01);
    t_push(8'hFF);
    t_pull(8'hA5);
    t_pull(8'h80);
    t_overrun();
    mode = 1'b0;
    do_reset();
    t_bad_stop();
    finish_run();
  end
endmodule